// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Synchronization

This block is the counting engine behind a pulse-width modulator. A two-stage prescaler divides the system clock into tick enables. On each tick the counter steps against a programmable period, either counting up, counting down, or counting up and down in a triangle. A synchronization event loads a phase value into the counter. In up-down mode that event also sets the direction the counter takes next.

The sync event can come from an external input or from a software strobe. A selectable sync output passes that event on, or marks the cycles where the count reaches zero or compare B. A debug-halt input stops the counter. The stop policy either allows one more step, or lets the current cycle finish before stopping. A third policy lets the counter run as if no halt were asserted. All inputs are plain control levels sampled every system clock. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `pwm_timebase`

## Requirements
- R1: The tick rate is the system clock divided by C×H. C is 2 raised to `div_coarse` (codes 0..7 give 1..128). H is 1 for `div_fast`=0, and 2×`div_fast` for codes 1..7 (2..14). A change of either code restarts the prescaler. The counter steps only on ticks, except when a sync load occurs.
- R2: With `cnt_mode`=00 (up), the count steps +1 per tick and goes from `period` back to 0.
- R3: With `cnt_mode`=01 (down), the count steps −1 per tick and goes from 0 back to `period`.
- R4: With `cnt_mode`=10 (up-down), the count rises to `period`, turns and falls to 0, then rises again. `count_up` is 1 while the count is rising.
- R5: A sync event loads `phase` into the count on the next clock edge. In up-down mode the following steps go down if `phase_dir` is 0 and up if it is 1. In up and down modes `phase_dir` has no effect.
- R6: `sw_sync`=1 acts as a sync event, ORed with `sync_in`, but only while `sync_sel`=00. Under any other `sync_sel` value it neither loads the count nor drives `sync_out`.
- R7: `sync_sel` picks the source of the registered one-clock `sync_out` pulse. 00: the combined sync event, one clock later. 01: the count has just stepped or loaded to 0. 10: the count has just stepped or loaded to `cmp_b`. 11: `sync_out` stays 0.
- R8: With `halt_mode`=00 and `dbg_halt`=1, the counter makes one more tick step and then holds. Steps resume after `dbg_halt` falls.
- R9: With `halt_mode`=01 and `dbg_halt`=1, the counter keeps stepping until it reaches its end point and then holds there. The end point is `period` in up mode and 0 in the other modes.
- R10: With `halt_mode` bit 1 set, `dbg_halt` has no effect on counting.
- R11: With `cnt_mode`=11, tick steps are suppressed and the count holds. Sync loads still apply.
- R12: During reset `count` is 0 and `sync_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_coarse | input | 3 | Power-of-two prescale code |
| div_fast | input | 3 | Even-step prescale code |
| cnt_mode | input | 2 | 00 up, 01 down, 10 up-down, 11 frozen |
| halt_mode | input | 2 | 00 stop after one step, 01 stop at cycle end, 1x ignore halt |
| phase_dir | input | 1 | Direction after sync in up-down mode (1 = up) |
| sync_sel | input | 2 | Sync output source select |
| sw_sync | input | 1 | Software sync strobe |
| period | input | CNT_W | Counter period |
| phase | input | CNT_W | Value loaded on sync |
| cmp_b | input | CNT_W | Compare value for sync output |
| sync_in | input | 1 | External sync event |
| dbg_halt | input | 1 | Debug halt request |
| sync_out | output | 1 | Registered sync output pulse |
| count | output | CNT_W | Counter value |
| count_up | output | 1 | Current count direction (1 = up) |

## Verification
The assertions check several rules on every cycle. The count never moves without a tick or a sync request. A sync request always lands the phase value. A pass-through sync always produces a sync-out pulse, and the disabled selection never does. The frozen mode holds the count, and up mode never runs past the period. Some behaviours only the scenarios can show, because they depend on a history of cycles. These are the exact divisor of each prescale code pair, the turning points of the triangle, the direction forced after a phase load, the single extra step of the first halt policy, and the end-of-cycle stop of the second. The placement of zero and compare pulses is also checked only by the scenarios.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;
  typedef enum logic [1:0] {
    CM_UP     = 2'b00,
    CM_DOWN   = 2'b01,
    CM_UPDOWN = 2'b10,
    CM_FREEZE = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SO_PASS = 2'b00,
    SO_ZERO = 2'b01,
    SO_CMPB = 2'b10,
    SO_OFF  = 2'b11
  } sync_sel_e;

  localparam logic [1:0] HM_STEP  = 2'b00;
  localparam logic [1:0] HM_CYCLE = 2'b01;
endpackage

// File: rtl/pwm_tbase_presc.sv
module pwm_tbase_presc #(
  parameter int CDIV_W = 3,
  parameter int HDIV_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CDIV_W-1:0] div_coarse,
  input  logic [HDIV_W-1:0] div_fast,
  output logic              tick
);
  localparam int PROD_W = HDIV_W + (1 << CDIV_W);

  logic [HDIV_W:0]   fast_div;
  logic [PROD_W-1:0] prod, prod_q, pcnt;
  logic              restart;

  // fast divisor: code 0 -> 1, otherwise twice the code
  always_comb begin
    if (div_fast == '0) fast_div = {{HDIV_W{1'b0}}, 1'b1};
    else                fast_div = {div_fast, 1'b0};
    prod = {{(PROD_W-HDIV_W-1){1'b0}}, fast_div} << div_coarse;
  end

  assign restart = (prod != prod_q);
  assign tick    = !restart && (pcnt == prod - PROD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      pcnt   <= '0;
    end else begin
      prod_q <= prod;
      if (restart || tick) pcnt <= '0;
      else                 pcnt <= pcnt + PROD_W'(1);
    end
  end
endmodule

// File: rtl/pwm_tbase_core.sv
module pwm_tbase_core
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sync_evt,
  input  logic [1:0]       cnt_mode,
  input  logic [1:0]       halt_mode,
  input  logic             dbg_halt,
  input  logic             phase_dir,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] phase,
  output logic [CNT_W-1:0] count,
  output logic             count_up,
  output logic             moved
);
  cnt_mode_e        mode;
  logic             up_q, halted_q;
  logic             at_end, hold, step;
  logic [CNT_W-1:0] nxt;
  logic             nxt_up;

  assign mode   = cnt_mode_e'(cnt_mode);
  assign at_end = (mode == CM_UP) ? (count == period) : (count == '0);
  assign hold   = dbg_halt && !halt_mode[1] &&
                  ((halt_mode == HM_STEP && halted_q) ||
                   (halt_mode == HM_CYCLE && at_end));
  assign step   = tick && !hold && (mode != CM_FREEZE);

  always_comb begin
    nxt    = count;
    nxt_up = up_q;
    case (mode)
      CM_UP:   nxt = (count >= period) ? '0 : count + CNT_W'(1);
      CM_DOWN: nxt = (count == '0) ? period : count - CNT_W'(1);
      CM_UPDOWN: begin
        if (up_q) begin
          if (count >= period) begin
            nxt_up = 1'b0;
            nxt    = (count == '0) ? '0 : count - CNT_W'(1);
          end else begin
            nxt = count + CNT_W'(1);
          end
        end else begin
          if (count == '0) begin
            nxt_up = 1'b1;
            nxt    = (period == '0) ? '0 : CNT_W'(1);
          end else begin
            nxt = count - CNT_W'(1);
          end
        end
      end
      default: nxt = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      up_q  <= 1'b1;
      moved <= 1'b0;
    end else if (sync_evt) begin
      count <= phase;
      if (mode == CM_UPDOWN) up_q <= phase_dir;
      moved <= 1'b1;
    end else if (step) begin
      count <= nxt;
      up_q  <= nxt_up;
      moved <= 1'b1;
    end else begin
      moved <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                halted_q <= 1'b0;
    else if (!dbg_halt || halt_mode != HM_STEP) halted_q <= 1'b0;
    else if (step)                             halted_q <= 1'b1;
  end

  always_comb begin
    case (mode)
      CM_UP:   count_up = 1'b1;
      CM_DOWN: count_up = 1'b0;
      default: count_up = up_q;
    endcase
  end
endmodule

// File: rtl/pwm_tbase_syncout.sv
module pwm_tbase_syncout
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sync_sel,
  input  logic             sync_evt,
  input  logic             moved,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp_b,
  output logic             sync_out
);
  sync_sel_e sel;
  logic      src;

  assign sel = sync_sel_e'(sync_sel);

  always_comb begin
    case (sel)
      SO_PASS: src = sync_evt;
      SO_ZERO: src = moved && (count == '0);
      SO_CMPB: src = moved && (count == cmp_b);
      default: src = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_out <= 1'b0;
    else        sync_out <= src;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CDIV_W = 3,
  parameter int HDIV_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CDIV_W-1:0] div_coarse,
  input  logic [HDIV_W-1:0] div_fast,
  input  logic [1:0]        cnt_mode,
  input  logic [1:0]        halt_mode,
  input  logic              phase_dir,
  input  logic [1:0]        sync_sel,
  input  logic              sw_sync,
  input  logic [CNT_W-1:0]  period,
  input  logic [CNT_W-1:0]  phase,
  input  logic [CNT_W-1:0]  cmp_b,
  input  logic              sync_in,
  input  logic              dbg_halt,
  output logic              sync_out,
  output logic [CNT_W-1:0]  count,
  output logic              count_up
);
  logic tick, sync_evt, moved;

  // software strobe only counts while the output passes the sync event
  assign sync_evt = sync_in || (sw_sync && (sync_sel == SO_PASS));

  pwm_tbase_presc #(.CDIV_W(CDIV_W), .HDIV_W(HDIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_coarse(div_coarse),
    .div_fast(div_fast), .tick(tick)
  );

  pwm_tbase_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sync_evt(sync_evt),
    .cnt_mode(cnt_mode), .halt_mode(halt_mode), .dbg_halt(dbg_halt),
    .phase_dir(phase_dir), .period(period), .phase(phase),
    .count(count), .count_up(count_up), .moved(moved)
  );

  pwm_tbase_syncout #(.CNT_W(CNT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .sync_sel(sync_sel), .sync_evt(sync_evt),
    .moved(moved), .count(count), .cmp_b(cmp_b), .sync_out(sync_out)
  );
endmodule

// File: rtl/pwm_tbase_chk.sv
module pwm_tbase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       cnt_mode,
  input logic [1:0]       sync_sel,
  input logic             sw_sync,
  input logic             sync_in,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] phase,
  input logic [CNT_W-1:0] count,
  input logic             sync_out
);
  a_r1_no_step_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sync_in && !sw_sync) |=> $stable(count));

  a_r2_up_within_period: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode == 2'b00 && count <= period && !sync_in && !sw_sync)
      |=> count <= $past(period));

  a_r5_phase_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> count == $past(phase));

  a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_sel == 2'b00 && (sync_in || sw_sync)) |=> sync_out);

  a_r7_output_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_sel == 2'b11) |=> !sync_out);

  a_r11_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode == 2'b11 && !sync_in && !sw_sync) |=> $stable(count));
endmodule

bind pwm_timebase pwm_tbase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_mode(cnt_mode),
  .sync_sel(sync_sel), .sw_sync(sw_sync), .sync_in(sync_in),
  .period(period), .phase(phase), .count(count), .sync_out(sync_out)
);

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       div_coarse = '0, div_fast = '0;
  logic [1:0]       cnt_mode = 2'b00, halt_mode = 2'b10, sync_sel = 2'b11;
  logic             phase_dir = 1'b0, sw_sync = 1'b0, sync_in = 1'b0, dbg_halt = 1'b0;
  logic [CNT_W-1:0] period = 16'd100, phase = '0, cmp_b = '0;
  logic             sync_out, count_up;
  logic [CNT_W-1:0] count;

  int vecs = 0, errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_timebase #(.CNT_W(CNT_W)) i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .div_coarse(div_coarse), .div_fast(div_fast),
    .cnt_mode(cnt_mode), .halt_mode(halt_mode), .phase_dir(phase_dir),
    .sync_sel(sync_sel), .sw_sync(sw_sync), .period(period), .phase(phase),
    .cmp_b(cmp_b), .sync_in(sync_in), .dbg_halt(dbg_halt),
    .sync_out(sync_out), .count(count), .count_up(count_up)
  );

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // sync load; returns at the negedge where count already shows ph
  task automatic load(int ph, bit dir);
    phase = CNT_W'(ph);
    phase_dir = dir;
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 count in reset", count, 0);
    chk("R12 sync_out in reset", sync_out, 0);
  endtask

  task automatic t_prescale(int c, int h, int exp);
    logic [CNT_W-1:0] prev;
    int n;
    cnt_mode = 2'b00; period = 16'hFFFF;
    div_coarse = 3'(c); div_fast = 3'(h);
    prev = count; n = 0;
    while (count == prev && n < 4000) begin @(negedge clk); n++; end
    prev = count; n = 0;
    while (count == prev && n < 4000) begin @(negedge clk); n++; end
    chk($sformatf("R1 divisor c=%0d h=%0d", c, h), n, exp);
  endtask

  task automatic t_up();
    cnt_mode = 2'b00; period = 16'd4;
    load(3, 0);
    @(negedge clk); chk("R2 up step", count, 4);
    @(negedge clk); chk("R2 up wrap", count, 0);
    @(negedge clk); chk("R2 up after wrap", count, 1);
  endtask

  task automatic t_down();
    cnt_mode = 2'b01; period = 16'd3;
    load(1, 1);
    @(negedge clk); chk("R3 down step", count, 0);
    @(negedge clk); chk("R3 down wrap", count, 3);
    @(negedge clk); chk("R3 down after wrap", count, 2);
  endtask

  task automatic t_updown();
    int exp_seq[5] = '{3, 2, 1, 0, 1};
    int exp_dir[5] = '{1, 0, 0, 0, 1};
    cnt_mode = 2'b10; period = 16'd3;
    load(2, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk($sformatf("R4 triangle step %0d", i), count, exp_seq[i]);
      chk($sformatf("R4 direction step %0d", i), count_up, exp_dir[i]);
    end
  endtask

  task automatic t_phase_dir();
    cnt_mode = 2'b10; period = 16'd10;
    load(5, 0); chk("R5 phase loaded", count, 5);
    @(negedge clk); chk("R5 up-down dir 0", count, 4);
    load(5, 1);
    @(negedge clk); chk("R5 up-down dir 1", count, 6);
    cnt_mode = 2'b00;
    load(5, 0);
    @(negedge clk); chk("R5 dir ignored in up", count, 6);
    cnt_mode = 2'b01;
    load(5, 1);
    @(negedge clk); chk("R5 dir ignored in down", count, 4);
  endtask

  task automatic t_sw_sync();
    cnt_mode = 2'b00; period = 16'd100; sync_sel = 2'b00;
    load(10, 0);
    chk("R7 pass sync_out", sync_out, 1);
    @(negedge clk); chk("R7 pass pulse ends", sync_out, 0);
    phase = 16'd50; sw_sync = 1'b1;
    @(negedge clk); sw_sync = 1'b0;
    chk("R6 sw sync loads", count, 50);
    chk("R6 sw sync drives out", sync_out, 1);
    sync_sel = 2'b01; phase = 16'd80; sw_sync = 1'b1;
    @(negedge clk); sw_sync = 1'b0;
    chk("R6 sw sync ignored count", count, 51);
    chk("R6 sw sync ignored out", sync_out, 0);
  endtask

  task automatic t_sync_out();
    cnt_mode = 2'b00; period = 16'd3; sync_sel = 2'b01;
    load(2, 0);
    @(negedge clk);
    @(negedge clk); chk("R7 zero not yet", sync_out, 0);
    @(negedge clk); chk("R7 zero pulse", sync_out, 1);
    @(negedge clk); chk("R7 zero pulse one clock", sync_out, 0);
    sync_sel = 2'b10; period = 16'd5; cmp_b = 16'd2;
    load(0, 0);
    @(negedge clk);
    @(negedge clk); chk("R7 cmp not yet", sync_out, 0);
    @(negedge clk); chk("R7 cmp pulse", sync_out, 1);
    sync_sel = 2'b11;
    load(4, 0);
    chk("R7 off still loads", count, 4);
    chk("R7 off no pulse", sync_out, 0);
  endtask

  task automatic t_halt();
    cnt_mode = 2'b00; period = 16'd100; halt_mode = 2'b00;
    load(10, 0);
    dbg_halt = 1'b1;
    wait_n(5); chk("R8 one step then hold", count, 11);
    dbg_halt = 1'b0;
    @(negedge clk); chk("R8 resumes", count, 12);
    period = 16'd20; halt_mode = 2'b01;
    load(15, 0);
    dbg_halt = 1'b1;
    wait_n(10); chk("R9 holds at period", count, 20);
    dbg_halt = 1'b0; halt_mode = 2'b10;
    @(negedge clk); chk("R9 resumes with wrap", count, 0);
    halt_mode = 2'b10; period = 16'd100;
    load(3, 0);
    dbg_halt = 1'b1;
    wait_n(4); chk("R10 free run", count, 7);
    halt_mode = 2'b11;
    wait_n(2); chk("R10 free run code 11", count, 9);
    dbg_halt = 1'b0;
  endtask

  task automatic t_freeze();
    cnt_mode = 2'b11;
    load(7, 0);
    chk("R11 load in frozen mode", count, 7);
    wait_n(3); chk("R11 frozen hold", count, 7);
    cnt_mode = 2'b00;
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(3);
    t_prescale(0, 0, 1);
    t_prescale(3, 0, 8);
    t_prescale(1, 1, 4);
    t_prescale(2, 3, 24);
    t_prescale(0, 7, 14);
    t_prescale(7, 0, 128);
    div_coarse = '0; div_fast = '0;
    wait_n(3);
    t_up();
    t_down();
    t_updown();
    t_phase_dir();
    t_sw_sync();
    t_sync_out();
    t_halt();
    t_freeze();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        vecs++; errs++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule